// File: doc/BRIEF.md
# Cascaded Interrupt Vectorizer

This block turns a set of level-sensitive interrupt lines into one encoded vector. It has two 8-bit local source groups, one 8-bit mapped source group, a CPU timer line, a bus-error line and two external timer lines. Each local group is qualified by its own mask register. The mapped group is shared: it is qualified by one of two mapped masks and feeds a chosen cascade bit in each local group. Priority is resolved first across the CPU-level lines and then inside the selected group. The result is a registered vector made of a source class, a bit index and a valid strobe.

Software reaches the four mask registers through a one-cycle write port. A read port returns the masks, the raw status inputs and the qualified pending values. The cascade bit of each local mask is not written directly. It follows whether the matching mapped mask holds any set bit, so enabling a mapped source also opens its path through the local group.

Top module: `irq_vectorizer`

## Requirements
- R1: The pending set of local group 0 is `loc0_stat_i & effective local mask 0`, and the same holds for group 1. A line with pending bits and no cascade bit pending gives class 1 (group 0) or class 2 (group 1), with the winning bit as index.
- R2: Within every group the highest-numbered pending bit wins, so bit 7 has the highest priority and bit 0 the lowest.
- R3: When the cascade bit (parameter `CASC0_BIT` / `CASC1_BIT`) is pending in a local group, the vector comes from `map_stat_i & mapped mask 0` as class 3 (group 0), or from `map_stat_i & mapped mask 1` as class 4 (group 1). This applies even when other bits of that local group are pending.
- R4: If the cascade path of the selected local line has no pending mapped bit, valid stays low in that cycle. Lower-priority lines are not served in its place.
- R5: When a mapped mask holds any set bit, the cascade bit of the matching local mask reads as 1. When the mapped mask becomes zero, that bit reads as 0.
- R6: A write to a local mask never changes its cascade bit. The other bits take the written value.
- R7: The line priority, highest first, is: CPU timer (class 0), local group 0, local group 1, bus error (class 5), external timers.
- R8: Either external timer line, alone or with the other, gives class 6 with index 0.
- R9: While reset is asserted and after it is released, all four masks read zero and valid is low.
- R10: The vector is registered and reflects inputs and masks one clock after they change. Class and index are zero whenever valid is low.
- R11: Addresses for write and read are: 0 local mask 0, 1 local mask 1, 2 mapped mask 0, 3 mapped mask 1. Read-only addresses are: 4 raw local 0, 5 raw local 1, 6 raw mapped, 8 pending local 0, 9 pending local 1, 10 mapped qualified by mask 0, 11 mapped qualified by mask 1. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_tmr_i | input | 1 | CPU timer request |
| bus_err_i | input | 1 | Bus-error request |
| ext_tmr0_i | input | 1 | External timer request A |
| ext_tmr1_i | input | 1 | External timer request B |
| loc0_stat_i | input | 8 | Live status of local group 0 |
| loc1_stat_i | input | 8 | Live status of local group 1 |
| map_stat_i | input | 8 | Live status of the shared mapped group |
| wr_en_i | input | 1 | One-cycle mask write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 8 | Read data, combinational from rd_addr_i |
| vec_valid_o | output | 1 | Vector valid |
| vec_class_o | output | 3 | Source class |
| vec_index_o | output | 3 | Winning bit index |

## Verification
The bench builds the block with the group-0 cascade at bit 7 and the group-1 cascade at bit 3. The lower cascade position lets the bench pend local bits above the cascade bit, which shows that the cascade path takes precedence over a higher-numbered local bit. The bit-7 position keeps the common case covered. The scoreboard model keeps its own copy of the masks, so the cascade-bit tracking, the ignored direct writes and the empty-cascade cases can be predicted without looking into the design.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  typedef enum logic [2:0] {
    CLS_CPU_TMR = 3'd0,
    CLS_LOC0    = 3'd1,
    CLS_LOC1    = 3'd2,
    CLS_MAP0    = 3'd3,
    CLS_MAP1    = 3'd4,
    CLS_BUSERR  = 3'd5,
    CLS_EXT_TMR = 3'd6
  } vec_class_e;

  localparam int unsigned REG_AW = 4;

  localparam logic [REG_AW-1:0] A_LMASK0 = 4'd0;
  localparam logic [REG_AW-1:0] A_LMASK1 = 4'd1;
  localparam logic [REG_AW-1:0] A_MMASK0 = 4'd2;
  localparam logic [REG_AW-1:0] A_MMASK1 = 4'd3;
  localparam logic [REG_AW-1:0] A_RAW0   = 4'd4;
  localparam logic [REG_AW-1:0] A_RAW1   = 4'd5;
  localparam logic [REG_AW-1:0] A_RAWM   = 4'd6;
  localparam logic [REG_AW-1:0] A_PEND0  = 4'd8;
  localparam logic [REG_AW-1:0] A_PEND1  = 4'd9;
  localparam logic [REG_AW-1:0] A_MQUAL0 = 4'd10;
  localparam logic [REG_AW-1:0] A_MQUAL1 = 4'd11;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned W  = 8,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);

  // Scan upward; the last set bit seen is the highest-numbered one.
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < int'(W); i++) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import irq_vec_pkg::*;
#(
  parameter int unsigned W         = 8,
  parameter int unsigned CASC0_BIT = 7,
  parameter int unsigned CASC1_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [W-1:0]      wr_data_i,
  output logic [W-1:0]      lmask0_o,
  output logic [W-1:0]      lmask1_o,
  output logic [W-1:0]      mmask0_o,
  output logic [W-1:0]      mmask1_o
);

  localparam logic [W-1:0] CASC0_M = W'(1) << CASC0_BIT;
  localparam logic [W-1:0] CASC1_M = W'(1) << CASC1_BIT;

  // Stored local masks never hold their cascade bit; it is derived.
  logic [W-1:0] lm0_q, lm1_q, mm0_q, mm1_q;
  logic [W-1:0] lm0_d, lm1_d, mm0_d, mm1_d;
  logic         lm0_en, lm1_en, mm0_en, mm1_en;

  always_comb begin
    lm0_en = wr_en_i && (wr_addr_i == A_LMASK0);
    lm1_en = wr_en_i && (wr_addr_i == A_LMASK1);
    mm0_en = wr_en_i && (wr_addr_i == A_MMASK0);
    mm1_en = wr_en_i && (wr_addr_i == A_MMASK1);
    lm0_d  = wr_data_i & ~CASC0_M;
    lm1_d  = wr_data_i & ~CASC1_M;
    mm0_d  = wr_data_i;
    mm1_d  = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lm0_q <= '0;
      lm1_q <= '0;
      mm0_q <= '0;
      mm1_q <= '0;
    end else begin
      if (lm0_en) lm0_q <= lm0_d;
      if (lm1_en) lm1_q <= lm1_d;
      if (mm0_en) mm0_q <= mm0_d;
      if (mm1_en) mm1_q <= mm1_d;
    end
  end

  assign lmask0_o = lm0_q | (CASC0_M & {W{|mm0_q}});
  assign lmask1_o = lm1_q | (CASC1_M & {W{|mm1_q}});
  assign mmask0_o = mm0_q;
  assign mmask1_o = mm1_q;

  AST_CASC0_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == A_MMASK0 && wr_data_i != '0) |=> lmask0_o[CASC0_BIT]); // R5
  AST_CASC1_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == A_MMASK1 && wr_data_i == '0) |=> !lmask1_o[CASC1_BIT]); // R5
  AST_LWR_CASC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == A_LMASK0) |=> (lmask0_o[CASC0_BIT] == $past(lmask0_o[CASC0_BIT]))); // R6

endmodule

// File: rtl/irq_vectorizer.sv
module irq_vectorizer
  import irq_vec_pkg::*;
#(
  parameter int unsigned W         = 8,
  parameter int unsigned CASC0_BIT = 7,
  parameter int unsigned CASC1_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_tmr_i,
  input  logic              bus_err_i,
  input  logic              ext_tmr0_i,
  input  logic              ext_tmr1_i,
  input  logic [W-1:0]      loc0_stat_i,
  input  logic [W-1:0]      loc1_stat_i,
  input  logic [W-1:0]      map_stat_i,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [W-1:0]      rd_data_o,
  output logic              vec_valid_o,
  output logic [2:0]        vec_class_o,
  output logic [$clog2(W)-1:0] vec_index_o
);

  localparam int unsigned IW     = $clog2(W);
  localparam int unsigned NGRP   = 4;
  localparam int unsigned G_LOC0 = 0;
  localparam int unsigned G_LOC1 = 1;
  localparam int unsigned G_MAP0 = 2;
  localparam int unsigned G_MAP1 = 3;

  logic [W-1:0] lmask0, lmask1, mmask0, mmask1;

  irq_mask_regs #(.W(W), .CASC0_BIT(CASC0_BIT), .CASC1_BIT(CASC1_BIT)) u_masks (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .lmask0_o  (lmask0),
    .lmask1_o  (lmask1),
    .mmask0_o  (mmask0),
    .mmask1_o  (mmask1)
  );

  // Qualified groups: two local, two views of the shared mapped status.
  logic [NGRP-1:0][W-1:0]  grp_pend;
  logic [NGRP-1:0]         grp_any;
  logic [NGRP-1:0][IW-1:0] grp_idx;

  assign grp_pend[G_LOC0] = loc0_stat_i & lmask0;
  assign grp_pend[G_LOC1] = loc1_stat_i & lmask1;
  assign grp_pend[G_MAP0] = map_stat_i  & mmask0;
  assign grp_pend[G_MAP1] = map_stat_i  & mmask1;

  for (genvar g = 0; g < NGRP; g++) begin : g_enc
    irq_prio_enc #(.W(W), .IW(IW)) u_enc (
      .req_i (grp_pend[g]),
      .any_o (grp_any[g]),
      .idx_o (grp_idx[g])
    );
  end

  // Next-state vector selection.
  logic          valid_d, valid_q;
  vec_class_e    cls_d, cls_q;
  logic [IW-1:0] idx_d, idx_q;
  logic          vec_en;

  always_comb begin
    valid_d = 1'b0;
    cls_d   = CLS_CPU_TMR;
    idx_d   = '0;
    if (cpu_tmr_i) begin
      valid_d = 1'b1;
    end else if (grp_any[G_LOC0]) begin
      if (grp_pend[G_LOC0][CASC0_BIT]) begin
        if (grp_any[G_MAP0]) begin
          valid_d = 1'b1;
          cls_d   = CLS_MAP0;
          idx_d   = grp_idx[G_MAP0];
        end
      end else begin
        valid_d = 1'b1;
        cls_d   = CLS_LOC0;
        idx_d   = grp_idx[G_LOC0];
      end
    end else if (grp_any[G_LOC1]) begin
      if (grp_pend[G_LOC1][CASC1_BIT]) begin
        if (grp_any[G_MAP1]) begin
          valid_d = 1'b1;
          cls_d   = CLS_MAP1;
          idx_d   = grp_idx[G_MAP1];
        end
      end else begin
        valid_d = 1'b1;
        cls_d   = CLS_LOC1;
        idx_d   = grp_idx[G_LOC1];
      end
    end else if (bus_err_i) begin
      valid_d = 1'b1;
      cls_d   = CLS_BUSERR;
    end else if (ext_tmr0_i || ext_tmr1_i) begin
      valid_d = 1'b1;
      cls_d   = CLS_EXT_TMR;
    end
  end

  // Hold the register while idle; load whenever old or new vector is live.
  assign vec_en = valid_d | valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cls_q   <= CLS_CPU_TMR;
      idx_q   <= '0;
    end else if (vec_en) begin
      valid_q <= valid_d;
      cls_q   <= cls_d;
      idx_q   <= idx_d;
    end
  end

  assign vec_valid_o = valid_q;
  assign vec_class_o = cls_q;
  assign vec_index_o = idx_q;

  // Readback mux.
  always_comb begin
    unique case (rd_addr_i)
      A_LMASK0: rd_data_o = lmask0;
      A_LMASK1: rd_data_o = lmask1;
      A_MMASK0: rd_data_o = mmask0;
      A_MMASK1: rd_data_o = mmask1;
      A_RAW0:   rd_data_o = loc0_stat_i;
      A_RAW1:   rd_data_o = loc1_stat_i;
      A_RAWM:   rd_data_o = map_stat_i;
      A_PEND0:  rd_data_o = grp_pend[G_LOC0];
      A_PEND1:  rd_data_o = grp_pend[G_LOC1];
      A_MQUAL0: rd_data_o = grp_pend[G_MAP0];
      A_MQUAL1: rd_data_o = grp_pend[G_MAP1];
      default:  rd_data_o = '0;
    endcase
  end

  AST_TMR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cpu_tmr_i)) |-> (vec_valid_o && vec_class_o == CLS_CPU_TMR)); // R7
  AST_LOC0_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && vec_class_o == CLS_LOC0) |-> (($past(grp_pend[G_LOC0]) >> vec_index_o) == W'(1))); // R2
  AST_MAP0_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && vec_class_o == CLS_MAP0) |-> (($past(grp_pend[G_MAP0]) >> vec_index_o) == W'(1))); // R3
  AST_EMPTY_CASC: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(cpu_tmr_i) && $past(grp_pend[G_LOC0][CASC0_BIT])
     && ($past(grp_pend[G_MAP0]) == '0)) |-> !vec_valid_o); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid_o |-> (vec_class_o == 3'd0 && vec_index_o == '0)); // R10

endmodule

// File: tb/tb_irq_vectorizer.sv
module tb_irq_vectorizer;

  localparam int unsigned W  = 8;
  localparam int unsigned C0 = 7;
  localparam int unsigned C1 = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_tmr, berr, ext0, ext1;
  logic [7:0] s0, s1, sm;
  logic       wr_en;
  logic [3:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       v_valid;
  logic [2:0] v_cls, v_idx;

  always #10 clk = ~clk;

  irq_vectorizer #(.W(W), .CASC0_BIT(C0), .CASC1_BIT(C1)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_tmr_i(cpu_tmr), .bus_err_i(berr),
    .ext_tmr0_i(ext0), .ext_tmr1_i(ext1), .loc0_stat_i(s0), .loc1_stat_i(s1),
    .map_stat_i(sm), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .vec_valid_o(v_valid),
    .vec_class_o(v_cls), .vec_index_o(v_idx)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [6:0] exp_q[$];
  string      tag_q[$];

  // Bench-side mask model: stored local bits exclude the cascade bit.
  logic [7:0] lm0_m = 8'h00, lm1_m = 8'h00, mm0_m = 8'h00, mm1_m = 8'h00;

  function automatic logic [7:0] eff0();
    return lm0_m | ((mm0_m != 0) ? (8'h01 << C0) : 8'h00);
  endfunction
  function automatic logic [7:0] eff1();
    return lm1_m | ((mm1_m != 0) ? (8'h01 << C1) : 8'h00);
  endfunction

  function automatic logic [2:0] top_bit(input logic [7:0] v);
    logic [2:0] r = 3'd0;
    for (int i = 0; i < 8; i++) if (v[i]) r = 3'(i);
    return r;
  endfunction

  function automatic logic [6:0] model();
    logic [7:0] p0, p1, q0, q1;
    p0 = s0 & eff0();
    p1 = s1 & eff1();
    q0 = sm & mm0_m;
    q1 = sm & mm1_m;
    if (cpu_tmr) return {1'b1, 3'd0, 3'd0};
    if (p0 != 0) begin
      if (p0[C0]) return (q0 != 0) ? {1'b1, 3'd3, top_bit(q0)} : 7'd0;
      return {1'b1, 3'd1, top_bit(p0)};
    end
    if (p1 != 0) begin
      if (p1[C1]) return (q1 != 0) ? {1'b1, 3'd4, top_bit(q1)} : 7'd0;
      return {1'b1, 3'd2, top_bit(p1)};
    end
    if (berr) return {1'b1, 3'd5, 3'd0};
    if (ext0 || ext1) return {1'b1, 3'd6, 3'd0};
    return 7'd0;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: applies stimulus and pushes the expected vector.
  task automatic apply(input string tag, input logic t, input logic b, input logic e0,
                       input logic e1, input logic [7:0] a0, input logic [7:0] a1,
                       input logic [7:0] am);
    @(posedge clk); #3;
    cpu_tmr = t; berr = b; ext0 = e0; ext1 = e1; s0 = a0; s1 = a1; sm = am;
    exp_q.push_back(model());
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #3;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    case (a)
      4'd0: lm0_m = d & ~(8'h01 << C0);
      4'd1: lm1_m = d & ~(8'h01 << C1);
      4'd2: mm0_m = d;
      4'd3: mm1_m = d;
      default: ;
    endcase
    @(posedge clk); #3;
    wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [7:0] exp);
    @(posedge clk); #3;
    rd_addr = a;
    #1;
    check(tag, rd_data, exp);
  endtask

  // Monitor: compares one registered result per cycle after each push.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        logic [6:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {1'b0, v_valid, v_cls, v_idx}, {1'b0, e});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    cpu_tmr = 0; berr = 0; ext0 = 0; ext1 = 0; s0 = 0; s1 = 0; sm = 0;
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    repeat (3) @(posedge clk);
    #3;
    check("R9 valid in reset", {7'd0, v_valid}, 8'd0);
    rst_n = 1'b1;
    // R9: masks zero after reset
    rd("R9 lmask0", 4'd0, 8'h00);
    rd("R9 mmask1", 4'd3, 8'h00);
    apply("R9 idle vector", 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF, 8'hFF);

    // R6: cascade bit of a direct write is dropped
    wr(4'd0, 8'hFF);
    wr(4'd1, 8'hFF);
    rd("R6 lmask0 no casc", 4'd0, 8'h7F);
    rd("R6 lmask1 no casc", 4'd1, 8'hF7);

    // R1 / R2: local groups
    apply("R1 R2 loc0 bits 4,1", 1'b0, 1'b0, 1'b0, 1'b0, 8'h12, 8'h00, 8'h00);
    apply("R1 R2 loc1 bits 2,0", 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h05, 8'h00);
    apply("R1 masked casc bit", 1'b0, 1'b0, 1'b0, 1'b0, 8'h80, 8'h00, 8'hFF);

    // R10: output does not follow input in the same cycle
    @(posedge clk); #3;
    cpu_tmr = 1'b1; s0 = 8'h00; sm = 8'h00;
    #2;
    check("R10 registered output", {7'd0, v_valid}, 8'd0);
    exp_q.push_back(model());
    tag_q.push_back("R10 one cycle later");

    // R5: mapped mask opens cascade
    wr(4'd2, 8'h24);
    rd("R5 lmask0 casc set", 4'd0, 8'hFF);
    apply("R3 map0 via casc", 1'b0, 1'b0, 1'b0, 1'b0, 8'h81, 8'h00, 8'h2C);
    apply("R4 empty casc0", 1'b0, 1'b1, 1'b0, 1'b0, 8'h80, 8'h00, 8'h08);

    wr(4'd3, 8'h81);
    rd("R5 lmask1 casc set", 4'd1, 8'hFF);
    apply("R3 map1 over higher loc1 bit", 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h48, 8'h80);
    apply("R4 empty casc1", 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h48, 8'h02);

    // R7 / R8: line priority
    apply("R7 timer over all", 1'b1, 1'b1, 1'b1, 1'b1, 8'h01, 8'h01, 8'hFF);
    apply("R7 loc0 over loc1", 1'b0, 1'b1, 1'b0, 1'b0, 8'h02, 8'h40, 8'h00);
    apply("R7 loc1 over buserr", 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h20, 8'h00);
    apply("R7 buserr over ext", 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 8'h00);
    apply("R8 ext timer B", 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00);
    apply("R8 ext timer A", 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00);
    apply("R10 back to idle", 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00);

    // R6: direct write cannot clear a managed cascade bit
    wr(4'd0, 8'h00);
    rd("R6 casc kept on clear", 4'd0, 8'h80);
    // R5: clearing mapped mask drops the cascade bit
    wr(4'd2, 8'h00);
    rd("R5 lmask0 casc cleared", 4'd0, 8'h00);
    apply("R5 closed cascade", 1'b0, 1'b0, 1'b0, 1'b0, 8'h80, 8'h00, 8'hFF);

    // R11: readback of raw and qualified values
    wr(4'd1, 8'h0F);
    rd("R11 raw loc0", 4'd4, 8'h80);
    rd("R11 raw map", 4'd6, 8'hFF);
    @(posedge clk); #3; s1 = 8'h3C;
    rd("R11 pend loc1", 4'd9, 8'h0C);
    rd("R11 map qual1", 4'd11, 8'h81);
    rd("R11 unused addr", 4'd13, 8'h00);

    repeat (4) @(posedge clk);
    finish_run();
  end

endmodule